// File: doc/BRIEF.md
# Multichannel Gain and Offset Correction Engine

This block keeps, for each of a set of output channels, a raw input code, a gain word and an offset word. From these it derives a corrected code. Software writes the three words over a plain address/data/strobe bus. One write can target a single channel, an aligned group of channels, or every channel at once. Each written channel is marked dirty, and a single shared multiply-and-add datapath works through the dirty channels one at a time, lowest index first.

The corrected codes go into a per-channel result store, which a downstream load controller reads through a combinational read port. Each time a result is stored, a one-cycle strobe on that channel's bit of `x2_upd` tells the load controller that new data has arrived. The active-low `busy_n` flag stays low for as long as any recalculation is queued or in flight. Writes are still accepted while `busy_n` is low. The time `busy_n` stays low therefore grows with the number of channels touched.

The correction is `corr = sat((raw * (gain + 1)) >> 13 + offset - 8192)`, clamped to 0..16383. With the reset gain (8191) and reset offset (8192), the corrected code equals the raw code. An offset below 8192 pulls the output down and an offset above 8192 pushes it up.

Top module: `chcal_engine`

## Requirements
- R1: After reset every raw code is 0, every gain word is 8191 and every offset word is 8192. Every stored corrected code reads 0, `busy_n` is high and `x2_upd` is all zero.
- R2: A stored corrected code equals (raw × (gain+1)) >> 13, plus offset, minus 8192. A negative result is stored as 0 and a result above 16383 is stored as 16383.
- R3: `wr_sel` picks the target word: 0 writes the raw code (14 bits), 1 writes the gain word (low 13 bits of `wr_data`) and 2 writes the offset word (14 bits). Any such write marks every targeted channel for recalculation. A write with `wr_sel` = 3 changes nothing and starts no work.
- R4: With `wr_all` high, a write targets every channel. Otherwise, with `wr_grp` high, it targets the aligned block of 8 channels whose index shares `wr_addr[5:3]`. Otherwise it targets channel `wr_addr` alone. Channel indices of 40 or more are never written.
- R5: Dirty channels are recalculated in ascending index order.
- R6: `busy_n` is low whenever a recalculation is queued or in flight. After one write touching N channels, with no further writes, `busy_n` stays low for exactly N+1 clock cycles.
- R7: Writes are accepted while `busy_n` is low. A channel rewritten while still queued is recalculated only once, using its latest words. A channel rewritten while its calculation is in flight is recalculated again.
- R8: Every store of a corrected code raises the matching bit of `x2_upd` for exactly one cycle, and at most one bit is high in any cycle. A write touching N channels, with nothing else pending, gives exactly one strobe per channel.
- R9: `rd_code` shows the stored corrected code of channel `rd_addr` in the same cycle. An index of 40 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Target word: 0 raw, 1 gain, 2 offset, 3 none |
| wr_addr | input | 6 | Channel index (or group selector) |
| wr_grp | input | 1 | Write the aligned group of 8 channels |
| wr_all | input | 1 | Write every channel |
| wr_data | input | 14 | Write data |
| rd_addr | input | 6 | Result store read index |
| rd_code | output | 14 | Stored corrected code of `rd_addr` |
| busy_n | output | 1 | Low while recalculation is queued or running |
| x2_upd | output | 40 | Per-channel one-cycle result-stored strobe |

## Verification
Some properties are checked by assertions on every cycle. These are: a channel's words stay put unless a write targets it; back-to-back launches climb in index when no new write arrives; a unity offset passes the scaled code through unchanged; the update strobes are one-hot and only follow a busy cycle; and any accepted write drives `busy_n` low next cycle. The arithmetic against the formula, the exact N+1 busy length, and the pulse counts cannot be shown by a per-cycle property. Neither can the once-only recalculation of a rewritten queued channel versus the repeat for one caught in flight, or the ignored selector and out-of-range indices. The bench scenarios cover these, comparing each of them with a reference model.

// File: rtl/chcal_pkg.sv
package chcal_pkg;
   typedef enum logic [1:0] {
      FLD_RAW  = 2'd0,
      FLD_GAIN = 2'd1,
      FLD_OFFS = 2'd2,
      FLD_NONE = 2'd3
   } fld_e;
endpackage

// File: rtl/chcal_regbank.sv
module chcal_regbank
   import chcal_pkg::*;
#(
   parameter int NCH = 40,
   parameter int XW  = 14,
   parameter int MW  = 13,
   parameter int CW  = 14,
   parameter int GRP = 8,
   parameter int AW  = 6,
   parameter int DW  = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [1:0]     wr_sel,
   input  logic [AW-1:0]  wr_addr,
   input  logic           wr_grp,
   input  logic           wr_all,
   input  logic [DW-1:0]  wr_data,
   input  logic [AW-1:0]  rd_ch,
   output logic [XW-1:0]  rd_raw,
   output logic [MW-1:0]  rd_gain,
   output logic [CW-1:0]  rd_offs,
   output logic [NCH-1:0] hit_mask
);
   localparam int GW = $clog2(GRP);
   localparam logic [MW-1:0] GAIN_RST = {MW{1'b1}};
   localparam logic [CW-1:0] OFFS_RST = CW'(1) << (CW-1);

   fld_e           fld;
   logic           wr_any;
   logic [XW-1:0]  raw_q  [NCH];
   logic [MW-1:0]  gain_q [NCH];
   logic [CW-1:0]  offs_q [NCH];

   assign fld    = fld_e'(wr_sel);
   assign wr_any = wr_en && (fld != FLD_NONE);

   for (genvar i = 0; i < NCH; i++) begin : g_hit
      localparam logic [AW-1:0]    CH_IDX = AW'(i);
      localparam logic [AW-GW-1:0] GR_IDX = CH_IDX[AW-1:GW];
      assign hit_mask[i] = wr_any &&
                           (wr_all ||
                            (wr_grp && (wr_addr[AW-1:GW] == GR_IDX)) ||
                            (!wr_grp && (wr_addr == CH_IDX)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            raw_q[i]  <= '0;
            gain_q[i] <= GAIN_RST;
            offs_q[i] <= OFFS_RST;
         end
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (hit_mask[i]) begin
               unique case (fld)
                  FLD_RAW:  raw_q[i]  <= wr_data[XW-1:0];
                  FLD_GAIN: gain_q[i] <= wr_data[MW-1:0];
                  FLD_OFFS: offs_q[i] <= wr_data[CW-1:0];
                  default:  ;
               endcase
            end
         end
      end
   end

   always_comb begin
      rd_raw  = '0;
      rd_gain = GAIN_RST;
      rd_offs = OFFS_RST;
      if (int'(rd_ch) < NCH) begin
         rd_raw  = raw_q[rd_ch];
         rd_gain = gain_q[rd_ch];
         rd_offs = offs_q[rd_ch];
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !hit_mask[i] |=> ($stable(raw_q[i]) && $stable(gain_q[i]) && $stable(offs_q[i])));
   end
endmodule

// File: rtl/chcal_sched.sv
module chcal_sched #(
   parameter int NCH = 40,
   parameter int AW  = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set_mask,
   output logic           pend_any,
   output logic           launch_v,
   output logic [AW-1:0]  launch_ch
);
   logic [NCH-1:0] pend_q;
   logic [NCH-1:0] launch_mask;

   always_comb begin
      launch_ch = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pend_q[i]) launch_ch = AW'(i);
      end
   end

   assign launch_v = |pend_q;
   assign pend_any = launch_v;

   for (genvar i = 0; i < NCH; i++) begin : g_lmask
      assign launch_mask[i] = launch_v && (launch_ch == AW'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~launch_mask) | set_mask;
   end

   p_pick_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      launch_v |-> pend_q[launch_ch]);
   p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_v && set_mask == '0) |=> (!launch_v || launch_ch > $past(launch_ch)));
   p_queue_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_mask) |=> pend_any);
endmodule

// File: rtl/chcal_datapath.sv
module chcal_datapath #(
   parameter int XW       = 14,
   parameter int MW       = 13,
   parameter int CW       = 14,
   parameter int AW       = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [AW-1:0] in_ch,
   input  logic [XW-1:0] in_raw,
   input  logic [MW-1:0] in_gain,
   input  logic [CW-1:0] in_offs,
   output logic          res_v,
   output logic [AW-1:0] res_ch,
   output logic [XW-1:0] res_code
);
   localparam int PW = XW + MW + 1;
   localparam int SW = XW + 2;
   localparam logic signed [SW-1:0] MID  = SW'(1) << (CW-1);
   localparam logic signed [SW-1:0] MAXC = SW'((1 << XW) - 1);

   logic [MW:0]           gain_p1;
   logic [PW-1:0]         prod;
   logic                  s1_v;
   logic [AW-1:0]         s1_ch;
   logic [XW-1:0]         s1_scaled;
   logic [CW-1:0]         s1_offs;
   logic signed [SW-1:0]  sum;

   assign gain_p1 = {1'b0, in_gain} + (MW+1)'(1);
   assign prod    = PW'(in_raw) * PW'(gain_p1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s1_ch     <= '0;
         s1_scaled <= '0;
         s1_offs   <= '0;
      end else begin
         s1_v <= in_v;
         if (in_v) begin
            s1_ch     <= in_ch;
            s1_scaled <= prod[XW+MW-1:MW];
            s1_offs   <= in_offs;
         end
      end
   end

   assign sum = $signed({2'b00, s1_scaled}) + $signed({{(SW-CW){1'b0}}, s1_offs}) - MID;

   if (SATURATE) begin : g_sat
      always_comb begin
         if (sum < 0)         res_code = '0;
         else if (sum > MAXC) res_code = MAXC[XW-1:0];
         else                 res_code = sum[XW-1:0];
      end
   end else begin : g_wrap
      assign res_code = sum[XW-1:0];
   end

   assign res_v  = s1_v;
   assign res_ch = s1_ch;

   p_unity_offs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_v && s1_offs == MID[CW-1:0]) |-> (res_code == s1_scaled));
endmodule

// File: rtl/chcal_engine.sv
module chcal_engine
   import chcal_pkg::*;
#(
   parameter int NCH      = 40,
   parameter int XW       = 14,
   parameter int MW       = 13,
   parameter int CW       = 14,
   parameter int GRP      = 8,
   parameter bit SATURATE = 1'b1,
   localparam int AW      = $clog2(NCH),
   localparam int DW      = (XW > CW) ? ((XW > MW) ? XW : MW) : ((CW > MW) ? CW : MW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [1:0]     wr_sel,
   input  logic [AW-1:0]  wr_addr,
   input  logic           wr_grp,
   input  logic           wr_all,
   input  logic [DW-1:0]  wr_data,
   input  logic [AW-1:0]  rd_addr,
   output logic [XW-1:0]  rd_code,
   output logic           busy_n,
   output logic [NCH-1:0] x2_upd
);
   if (NCH < 2)                         $error("NCH must be at least 2");
   if (GRP < 2 || (GRP & (GRP-1)) != 0) $error("GRP must be a power of two >= 2");
   if ($clog2(GRP) >= AW)               $error("GRP must be smaller than the channel space");
   if (CW != XW)                        $error("offset width must equal code width");
   if (MW >= XW + 2)                    $error("gain word too wide");

   logic [NCH-1:0] hit_mask;
   logic           pend_any;
   logic           launch_v;
   logic [AW-1:0]  launch_ch;
   logic [XW-1:0]  op_raw;
   logic [MW-1:0]  op_gain;
   logic [CW-1:0]  op_offs;
   logic           res_v;
   logic [AW-1:0]  res_ch;
   logic [XW-1:0]  res_code;
   logic [XW-1:0]  store_q [NCH];
   logic [NCH-1:0] upd_q;

   chcal_regbank #(
      .NCH(NCH), .XW(XW), .MW(MW), .CW(CW), .GRP(GRP), .AW(AW), .DW(DW)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
      .wr_grp(wr_grp), .wr_all(wr_all), .wr_data(wr_data),
      .rd_ch(launch_ch), .rd_raw(op_raw), .rd_gain(op_gain), .rd_offs(op_offs),
      .hit_mask(hit_mask)
   );

   chcal_sched #(.NCH(NCH), .AW(AW)) u_sched (
      .clk(clk), .rst_n(rst_n),
      .set_mask(hit_mask),
      .pend_any(pend_any),
      .launch_v(launch_v),
      .launch_ch(launch_ch)
   );

   chcal_datapath #(
      .XW(XW), .MW(MW), .CW(CW), .AW(AW), .SATURATE(SATURATE)
   ) u_dp (
      .clk(clk), .rst_n(rst_n),
      .in_v(launch_v), .in_ch(launch_ch),
      .in_raw(op_raw), .in_gain(op_gain), .in_offs(op_offs),
      .res_v(res_v), .res_ch(res_ch), .res_code(res_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) store_q[i] <= '0;
         upd_q <= '0;
      end else begin
         upd_q <= '0;
         for (int i = 0; i < NCH; i++) begin
            if (res_v && res_ch == AW'(i)) begin
               store_q[i] <= res_code;
               upd_q[i]   <= 1'b1;
            end
         end
      end
   end

   assign busy_n  = !(pend_any || res_v);
   assign x2_upd  = upd_q;
   assign rd_code = (int'(rd_addr) < NCH) ? store_q[rd_addr] : '0;

   p_upd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(x2_upd));
   p_upd_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|x2_upd) |-> !$past(busy_n));
   p_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_mask) |=> !busy_n);
endmodule

// File: tb/chcal_engine_test.sv
module chcal_engine_test;
   localparam int NCH = 40;
   localparam int AW  = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [1:0]     wr_sel = '0;
   logic [AW-1:0]  wr_addr = '0;
   logic           wr_grp = 1'b0;
   logic           wr_all = 1'b0;
   logic [13:0]    wr_data = '0;
   logic [AW-1:0]  rd_addr = '0;
   logic [13:0]    rd_code;
   logic           busy_n;
   logic [NCH-1:0] x2_upd;

   int checks = 0;
   int fails  = 0;
   int m_raw  [NCH];
   int m_gain [NCH];
   int m_offs [NCH];
   int upd_cnt [NCH];
   int upd_log [256];
   int log_n = 0;
   int busy_cnt = 0;
   bit exp_hit [NCH];

   always #10 clk = ~clk;

   chcal_engine uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
      .wr_grp(wr_grp), .wr_all(wr_all), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_code(rd_code), .busy_n(busy_n), .x2_upd(x2_upd)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (!busy_n) busy_cnt++;
         for (int i = 0; i < NCH; i++) begin
            if (x2_upd[i]) begin
               upd_cnt[i]++;
               if (log_n < 256) upd_log[log_n] = i;
               log_n++;
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_code(input int ch);
      int s;
      s = ((m_raw[ch] * (m_gain[ch] + 1)) >>> 13) + m_offs[ch] - 8192;
      if (s < 0) s = 0;
      if (s > 16383) s = 16383;
      return s;
   endfunction

   function automatic int mark_hits(input int addr, input bit grp, input bit all, input int sel);
      int n = 0;
      for (int i = 0; i < NCH; i++) begin
         exp_hit[i] = (sel != 3) && (all || (grp && (i / 8 == addr / 8)) || (!grp && i == addr));
         if (exp_hit[i]) n++;
      end
      return n;
   endfunction

   task automatic clear_counts();
      busy_cnt = 0;
      log_n = 0;
      for (int i = 0; i < NCH; i++) upd_cnt[i] = 0;
   endtask

   task automatic do_write(input int sel, input int addr, input bit grp, input bit all, input int data);
      int n;
      n = mark_hits(addr, grp, all, sel);
      for (int i = 0; i < NCH; i++) begin
         if (exp_hit[i]) begin
            if (sel == 0) m_raw[i]  = data & 16'h3fff;
            if (sel == 1) m_gain[i] = data & 16'h1fff;
            if (sel == 2) m_offs[i] = data & 16'h3fff;
         end
      end
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = AW'(addr);
      wr_grp = grp; wr_all = all; wr_data = 14'(data);
      @(negedge clk);
      wr_en = 1'b0; wr_grp = 1'b0; wr_all = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (!busy_n && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      #1;
   endtask

   task automatic check_store(input string req);
      for (int i = 0; i < NCH; i++) begin
         rd_addr = AW'(i);
         #1;
         check(req, int'(rd_code), ref_code(i), $sformatf("code ch%0d", i));
      end
   endtask

   task automatic run_op(input int sel, input int addr, input bit grp, input bit all, input int data);
      int n;
      int prev;
      bit ok;
      @(negedge clk);
      clear_counts();
      n = mark_hits(addr, grp, all, sel);
      do_write(sel, addr, grp, all, data);
      wait_idle();
      check("R6", busy_cnt, (n == 0) ? 0 : n + 1, "busy length");
      ok = 1'b1;
      for (int i = 0; i < NCH; i++) if (upd_cnt[i] != (exp_hit[i] ? 1 : 0)) ok = 1'b0;
      check("R8", int'(ok), 1, "strobe per channel");
      check("R8", log_n, n, "strobe total");
      prev = -1; ok = 1'b1;
      for (int k = 0; k < log_n && k < 256; k++) begin
         if (upd_log[k] <= prev) ok = 1'b0;
         prev = upd_log[k];
      end
      check("R5", int'(ok), 1, "ascending service");
      check_store((sel == 1) ? "R3" : (all || grp) ? "R4" : "R2");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'h5eed1234);
      for (int i = 0; i < NCH; i++) begin
         m_raw[i] = 0; m_gain[i] = 8191; m_offs[i] = 8192; upd_cnt[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: reset state
      check("R1", int'(busy_n), 1, "busy_n after reset");
      check("R1", int'(x2_upd != '0), 0, "strobes after reset");
      check_store("R1");

      // R1: reset gain/offset give identity
      run_op(0, 3, 0, 0, 12345);
      check("R1", ref_code(3), 12345, "identity model");
      rd_addr = 6'd3; #1;
      check("R1", int'(rd_code), 12345, "identity output");

      // R3: ignored selector and out-of-range index
      clear_counts();
      do_write(3, 3, 0, 0, 777);
      @(negedge clk); #1;
      check("R3", busy_cnt, 0, "sel 3 busy");
      rd_addr = 6'd3; #1;
      check("R3", int'(rd_code), 12345, "sel 3 store");
      clear_counts();
      do_write(0, 45, 0, 0, 999);
      @(negedge clk); #1;
      check("R4", busy_cnt, 0, "index 45 busy");
      do_write(0, 44, 1, 0, 999);
      @(negedge clk); #1;
      check("R4", busy_cnt, 0, "empty group busy");
      rd_addr = 6'd45; #1;
      check("R9", int'(rd_code), 0, "out-of-range read");

      // R4: group and broadcast writes
      run_op(0, 13, 1, 0, 9000);
      run_op(0, 0, 0, 1, 16383);
      run_op(2, 0, 0, 1, 8292);

      // R2: saturation corners
      run_op(2, 7, 0, 0, 16383);
      run_op(2, 9, 0, 0, 0);
      run_op(0, 9, 0, 0, 100);
      run_op(1, 20, 0, 0, 0);
      run_op(1, 21, 0, 0, 7801);
      run_op(2, 22, 0, 0, 8036);

      // R7: rewrites while busy
      @(negedge clk);
      clear_counts();
      do_write(0, 0, 0, 1, 5000);
      do_write(0, 0, 0, 0, 6000);
      do_write(2, 39, 0, 0, 8000);
      wait_idle();
      check("R7", upd_cnt[0], 2, "in-flight rewrite recalculated");
      check("R7", upd_cnt[39], 1, "queued rewrite once");
      check_store("R7");

      // random mix
      for (int r = 0; r < 40; r++) begin
         int kind = $urandom_range(0, 9);
         int sel  = $urandom_range(0, 2);
         int addr = $urandom_range(0, NCH - 1);
         int data = $urandom_range(0, 16383);
         if (r % 7 == 0) data = 0;
         if (r % 7 == 1) data = 16383;
         run_op(sel, addr, kind == 0, kind == 1, data);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule